// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter Bank

This block sits between a bank of raw digital pin inputs and the logic that detects pin events. Each pin has its own glitch filter, so a short pulse or a bounce on a pin never reaches the event logic. A pin's filtered output takes a new level only after the raw input has held that level for a programmed number of filter ticks. One length value applies to every pin.

The filter ticks either on every cycle of the bus clock or on a one-cycle `slow_tick` pulse. That pulse is the slow low-power clock after it has been brought into the bus clock domain. Software sets up the block through three small registers: a per-pin enable mask, a tick source select and a 5-bit length. Each register is written in a single cycle. Reads return the register chosen by `reg_addr` one cycle later. A disabled pin drives a constant low. An enabled pin that is not set up as a digital input passes its raw level through without filtering.

Top module: `glitch_filter_bank`

## Requirements
- R1: After a synchronous reset, all three registers read as zero and every filtered output is low.
- R2: Writing address 0 sets the enable mask, one bit per pin (bit n enables pin n), and reading address 0 returns all 32 bits.
- R3: Address 1 bit 0 selects the tick source (0: every bus clock cycle, 1: only cycles with `slow_tick` high), and bits 31:1 of address 1 read as zero.
- R4: Address 2 bits 4:0 hold the filter length L, and bits 31:5 read as zero. Address 3 holds nothing and reads as zero.
- R5: A pin whose enable bit is 0 drives a low filtered output from the clock edge after the enable is seen low, whatever its raw input.
- R6: An enabled pin whose `pin_dig_in` bit is 0 bypasses the filter: its output equals its raw input one clock cycle later.
- R7: An enabled digital-input pin changes its output to the raw level at the (L+1)-th consecutive tick on which the raw level differs from the output.
- R8: A raw level that returns to the output level before L+1 ticks leaves the output unchanged and restarts the count from zero.
- R9: With L = 0, a filtered pin follows a raw change at the first tick, one cycle later when the bus clock is selected.
- R10: With the slow source selected, the filter state does not advance on cycles where `slow_tick` is low.
- R11: A write to address 1 or address 2 clears every filter count, so a change already in progress needs a full L+1 ticks afresh. The write leaves the filtered outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, registered (one cycle latency) |
| slow_tick | input | 1 | One-cycle pulse from the slow clock, already synchronised |
| pin_raw | input | 32 | Raw pin levels |
| pin_dig_in | input | 32 | Per-pin flag: pin is set up as a digital input |
| pin_filt | output | 32 | Filtered pin levels, registered |

## Verification
Each fault in the filter state shows up as a change on `pin_filt` that comes too early or too late. A counter that fails to clear makes the output move before L+1 matching ticks. A counter that fails to advance delays it past that tick. A stray count on a cycle with no tick moves the output while `slow_tick` is low. The bench therefore samples the output on the tick just before the expected change and again on the tick of the change. Glitches of exactly L ticks and a length rewrite in the middle of a count expose off-by-one errors within one tick of where they occur. A register fault appears on `reg_rdata` in the cycle after the address is presented.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int GF_ADDR_W = 2;

  typedef enum logic [GF_ADDR_W-1:0] {
    GF_ADDR_ENABLE = 2'd0,
    GF_ADDR_CLKSEL = 2'd1,
    GF_ADDR_LEN    = 2'd2,
    GF_ADDR_SPARE  = 2'd3
  } gf_addr_e;
endpackage

// File: rtl/gf_regs.sv
module gf_regs
  import gf_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_i,
  input  logic [GF_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NPINS-1:0]     en_o,
  output logic                 slow_sel_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 clr_o
);

  logic [NPINS-1:0]  en_q;
  logic              sel_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] rdata_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= 1'b0;
      len_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        GF_ADDR_ENABLE: en_q  <= reg_wdata_i[NPINS-1:0];
        GF_ADDR_CLKSEL: sel_q <= reg_wdata_i[0];
        GF_ADDR_LEN:    len_q <= reg_wdata_i[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      case (reg_addr_i)
        GF_ADDR_ENABLE: rdata_q[NPINS-1:0] <= en_q;
        GF_ADDR_CLKSEL: rdata_q[0]         <= sel_q;
        GF_ADDR_LEN:    rdata_q[LEN_W-1:0] <= len_q;
        default: ;
      endcase
    end
  end

  // a timing-setting write restarts every filter count
  assign clr_o = reg_wr_i &&
                 (reg_addr_i == GF_ADDR_CLKSEL || reg_addr_i == GF_ADDR_LEN);

  assign en_o        = en_q;
  assign slow_sel_o  = sel_q;
  assign len_o       = len_q;
  assign reg_rdata_o = rdata_q;

  p_sel_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == GF_ADDR_CLKSEL) |=> (reg_rdata_o[DATA_W-1:1] == '0));

  p_len_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == GF_ADDR_LEN) |=> (reg_rdata_o[DATA_W-1:LEN_W] == '0));

  p_spare_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_addr_i == GF_ADDR_SPARE) |=> (reg_rdata_o == '0));

endmodule

// File: rtl/gf_tick_sel.sv
module gf_tick_sel (
  input  logic slow_sel_i,
  input  logic slow_tick_i,
  output logic tick_o
);
  // fast source: every bus cycle is a tick
  assign tick_o = slow_sel_i ? slow_tick_i : 1'b1;
endmodule

// File: rtl/gf_pin_filter.sv
module gf_pin_filter #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             dig_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             raw_i,
  output logic             filt_o
);

  logic [LEN_W-1:0] cnt_q;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (!dig_i) begin
      out_q <= raw_i;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (raw_i == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= len_i) begin
        out_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = out_q;

  p_off_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !filt_o);

  p_cnt_le_len_r7: assert property (@(posedge clk) disable iff (rst)
    en_i && dig_i |-> (cnt_q <= len_i));

  p_no_tick_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && dig_i && !tick_i && !clr_i) |=> ($stable(filt_o) && $stable(cnt_q)));

  p_clear_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (en_i && dig_i && clr_i) |=> ($stable(filt_o) && cnt_q == '0));

endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
  import gf_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [GF_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 slow_tick,
  input  logic [NPINS-1:0]     pin_raw,
  input  logic [NPINS-1:0]     pin_dig_in,
  output logic [NPINS-1:0]     pin_filt
);

  logic [NPINS-1:0] en;
  logic             slow_sel;
  logic [LEN_W-1:0] len;
  logic             clr;
  logic             tick;

  gf_regs #(
    .NPINS  (NPINS),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .en_o        (en),
    .slow_sel_o  (slow_sel),
    .len_o       (len),
    .clr_o       (clr)
  );

  gf_tick_sel u_tick (
    .slow_sel_i  (slow_sel),
    .slow_tick_i (slow_tick),
    .tick_o      (tick)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gf_pin_filter #(
      .LEN_W (LEN_W)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en[p]),
      .dig_i  (pin_dig_in[p]),
      .tick_i (tick),
      .clr_i  (clr),
      .len_i  (len),
      .raw_i  (pin_raw[p]),
      .filt_o (pin_filt[p])
    );
  end

endmodule

// File: tb/glitch_filter_bank_tb.sv
module glitch_filter_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        slow_tick = 1'b0;
  logic [31:0] pin_raw = '0;
  logic [31:0] pin_dig_in = '0;
  logic [31:0] pin_filt;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  glitch_filter_bank u_dut (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .slow_tick  (slow_tick),
    .pin_raw    (pin_raw),
    .pin_dig_in (pin_dig_in),
    .pin_filt   (pin_filt)
  );

  // register vectors: address, write data, expected read-back
  localparam int NV = 7;
  localparam logic [1:0]  V_ADDR [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0};
  localparam logic [31:0] V_WDAT [NV] = '{32'hA5A5_0F0F, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                                          32'hFFFF_FFFF, 32'h0000_0025, 32'hFFFF_FFFF,
                                          32'h0000_0000};
  localparam logic [31:0] V_EXP  [NV] = '{32'hA5A5_0F0F, 32'h0000_0001, 32'h0000_0000,
                                          32'h0000_001F, 32'h0000_0005, 32'h0000_0000,
                                          32'h0000_0000};
  // tags: R2, R3, R3, R4, R4, R4, R2
  localparam string V_TAG [NV] = '{"R2", "R3", "R3", "R4", "R4", "R4", "R2"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);

    // R1: reset state
    chk("R1 filt", pin_filt, 32'h0);
    rd_chk(2'd0, 32'h0, "R1 enable");
    rd_chk(2'd1, 32'h0, "R1 clksel");
    rd_chk(2'd2, 32'h0, "R1 len");

    // register vector walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WDAT[i]);
      rd_chk(V_ADDR[i], V_EXP[i], V_TAG[i]);
    end

    // R5: disabled pins stay low
    pin_dig_in = 32'hFFFF_FFFF;
    pin_raw    = 32'hFFFF_FFFF;
    step(5);
    chk("R5 disabled", pin_filt, 32'h0);

    // R6 / R7: upper half filtered, lower half bypassed, L=3, fast tick
    pin_raw    = 32'h0;
    pin_dig_in = 32'hFFFF_0000;
    wr(2'd1, 32'h0);
    wr(2'd2, 32'd3);
    wr(2'd0, 32'hFFFF_FFFF);
    step(2);
    pin_raw = 32'hFFFF_FFFF;
    step(1);
    chk("R6 bypass", pin_filt, 32'h0000_FFFF);
    step(2);
    chk("R7 before L+1", pin_filt, 32'h0000_FFFF);
    step(1);
    chk("R7 at L+1", pin_filt, 32'hFFFF_FFFF);

    // R8: glitches of L ticks are rejected and the count restarts
    pin_dig_in = 32'hFFFF_FFFF;
    step(1);
    pin_raw = 32'h0;
    step(3);
    pin_raw = 32'hFFFF_FFFF;
    step(3);
    chk("R8 glitch rejected", pin_filt, 32'hFFFF_FFFF);
    pin_raw = 32'h0;
    step(3);
    pin_raw = 32'hFFFF_FFFF;
    step(1);
    pin_raw = 32'h0;
    step(3);
    chk("R8 count restarted", pin_filt, 32'hFFFF_FFFF);
    step(1);
    chk("R8 change after restart", pin_filt, 32'h0);

    // R9: length zero
    wr(2'd2, 32'd0);
    pin_raw = 32'h5A5A_5A5A;
    step(1);
    chk("R9 one tick", pin_filt, 32'h5A5A_5A5A);
    pin_raw = 32'hFFFF_FFFF;
    step(1);
    chk("R9 follow", pin_filt, 32'hFFFF_FFFF);

    // R10: slow tick source, L=1
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd1);
    pin_raw = 32'h0;
    step(10);
    chk("R10 no tick", pin_filt, 32'hFFFF_FFFF);
    slow_tick = 1'b1;
    step(1);
    slow_tick = 1'b0;
    chk("R10 one tick", pin_filt, 32'hFFFF_FFFF);
    step(3);
    chk("R10 idle", pin_filt, 32'hFFFF_FFFF);
    slow_tick = 1'b1;
    step(1);
    slow_tick = 1'b0;
    chk("R10 second tick", pin_filt, 32'h0);

    // R11: rewriting the length mid-count restarts it
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd3);
    pin_raw = 32'hFFFF_FFFF;
    step(2);
    wr(2'd2, 32'd3);
    chk("R11 output kept", pin_filt, 32'h0);
    step(3);
    chk("R11 count cleared", pin_filt, 32'h0);
    step(1);
    chk("R11 full count", pin_filt, 32'hFFFF_FFFF);

    // R5: disabling forces low at the next edge
    wr(2'd0, 32'h0000_FFFF);
    step(1);
    chk("R5 disable", pin_filt, 32'h0000_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule